// File: doc/BRIEF.md
# Branch and Call Stack Unit

This unit owns the 16-bit program counter of a small 8-bit processor and picks the next fetch address for every instruction it is handed. Each instruction arrives already gathered: the opcode byte plus the two address bytes that follow it (low byte, then high byte). The unit also samples the accumulator-zero flag, the carry flag and an external test pin. With these it resolves plain sequential flow, unconditional jumps, masked conditional jumps, subroutine calls and returns, and the increment-and-branch instruction.

Return addresses sit in a private byte-wide stack RAM, two bytes per nesting level. A return pops the top entry into the program counter. In the same cycle it hands a 4-bit immediate to the accumulator load path. For increment-and-branch, the register file supplies the current register value. The unit returns the incremented value and a zero flag, so the register file can write the result back on the same clock edge. A call into a full stack or a return from an empty one sets a sticky error flag.

Top module: `flow_ctrl_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc` becomes 0x0000 and `stack_err` becomes 0.
- R2: An instruction that does not redirect flow advances `pc` by its length, modulo 2^16. Length is 2 for opcodes 0010xxx0, 0xE1 and 0xEA. Length is 3 for opcodes 0011xxx1 and 0111xxx1. Length is 1 for every other opcode outside the flow group, including 0x00.
- R3: Opcode 0x40 loads `pc` with {`addr_hi`,`addr_lo`}.
- R4: For opcode 0001abcd, a selects inversion, b selects accumulator-zero, c selects carry and d selects the test pin. The jump is taken when (b&zero | c&carry | d&test) XOR a is 1. A taken jump loads the target; otherwise `pc` advances by 3.
- R5: Opcode 0x50 pushes `pc`+3 onto the stack and loads the target.
- R6: Opcode 1100dddd pops the most recently pushed address into `pc`, so entries come back last-in first-out. In the same cycle `acc_load` is 1 and `acc_imm` equals dddd.
- R7: For opcode 0111rrr0, `isz_result` = `isz_reg_in`+1 modulo 256 and `isz_zero` is 1 exactly when that result is 0. The target is loaded when the result is non-zero; otherwise `pc` advances by 3.
- R8: A call made when the stack already holds STACK_BYTES/2 entries sets `stack_err`, advances `pc` by 3 and leaves the stored entries untouched.
- R9: A return made on an empty stack sets `stack_err`, advances `pc` by 1 and still drives `acc_load` with the immediate.
- R10: Once set, `stack_err` stays 1 until reset.
- R11: While `instr_valid` is 0, `pc` holds its value and `acc_load` is 0, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | First byte of the instruction |
| addr_lo | input | 8 | Low byte of the target address |
| addr_hi | input | 8 | High byte of the target address |
| acc_zero | input | 1 | Accumulator equals zero |
| carry_flag | input | 1 | Carry/link flag |
| test_pin | input | 1 | External test input |
| isz_reg_in | input | 8 | Current value of the register named by increment-and-branch |
| pc | output | 16 | Program counter |
| acc_load | output | 1 | Accumulator takes `acc_imm` this cycle |
| acc_imm | output | 4 | Immediate for the accumulator on return |
| isz_result | output | 8 | Incremented register value |
| isz_zero | output | 1 | Incremented register value is zero |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench builds the unit with STACK_BYTES set to 8, which allows four nesting levels. With that setting a fifth nested call hits the overflow path after a few cycles. The same setting lets the bench unwind a full stack and check the last-in first-out order of every entry. The default byte width is kept, so the program counter stays 16 bits and the wrap from 0xFFFE to 0x0000 can be reached with one jump and a two-byte instruction.

// File: rtl/fcu_pkg.sv
// fcu_pkg: shared opcode constants and decoded-instruction types for the
// flow control unit. Assumes 8-bit opcodes with fixed field positions.
package fcu_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_JUMP = 8'h40;
    localparam logic [OPC_W-1:0] OPC_CALL = 8'h50;
    localparam logic [OPC_W-1:0] OPC_PORT_WR = 8'hE1;
    localparam logic [OPC_W-1:0] OPC_PORT_RD = 8'hEA;

    // Flow class of one instruction
    typedef enum logic [2:0] {
        FK_SEQ  = 3'd0,
        FK_JUMP = 3'd1,
        FK_COND = 3'd2,
        FK_CALL = 3'd3,
        FK_RET  = 3'd4,
        FK_ISZ  = 3'd5
    } flow_kind_e;

    // Decoder output
    typedef struct packed {
        flow_kind_e kind;
        logic [1:0] len;
        logic [3:0] cond;
        logic [3:0] imm;
    } flow_dec_t;

endpackage

// File: rtl/fcu_decode.sv
// fcu_decode: classifies an opcode into a flow kind and gives its byte
// length, condition nibble and return immediate. Purely combinational.
// Assumes opcode bit fields as listed in the requirements.
module fcu_decode
    import fcu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output flow_dec_t        dec
);

    // Map opcode patterns to flow kind and length
    always_comb begin
        dec.kind = FK_SEQ;
        dec.len  = 2'd1;
        dec.cond = opcode[3:0];
        dec.imm  = opcode[3:0];
        casez (opcode)
            8'b0001_????: begin
                dec.kind = FK_COND;
                dec.len  = 2'd3;
            end
            OPC_JUMP: begin
                dec.kind = FK_JUMP;
                dec.len  = 2'd3;
            end
            OPC_CALL: begin
                dec.kind = FK_CALL;
                dec.len  = 2'd3;
            end
            8'b0111_???0: begin
                dec.kind = FK_ISZ;
                dec.len  = 2'd3;
            end
            8'b1100_????: begin
                dec.kind = FK_RET;
                dec.len  = 2'd1;
            end
            8'b0010_???0: dec.len = 2'd2;
            8'b0011_???1: dec.len = 2'd3;
            8'b0111_???1: dec.len = 2'd3;
            OPC_PORT_WR:  dec.len = 2'd2;
            OPC_PORT_RD:  dec.len = 2'd2;
            default:      dec.len = 2'd1;
        endcase
    end

endmodule

// File: rtl/fcu_cond.sv
// fcu_cond: evaluates the masked condition of a conditional jump.
// Bit NSRC of the mask inverts; lower bits select one source each, with
// the highest select bit pairing with source 0. Selected sources are ORed.
module fcu_cond #(
    parameter int NSRC = 3
) (
    input  logic [NSRC:0]   mask,
    input  logic [NSRC-1:0] sources,
    output logic            taken
);

    logic [NSRC-1:0] hit;

    // One gate per selectable source
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = mask[NSRC-1-i] & sources[i];
    end

    // OR the selected terms, then apply the invert bit
    always_comb begin
        taken = (|hit) ^ mask[NSRC];
    end

endmodule

// File: rtl/fcu_stack.sv
// fcu_stack: byte-wide return stack holding ENTRY_BYTES bytes per entry.
// Push writes all bytes of an entry in one cycle; pop reads the top entry
// combinationally. Overflow or underflow leaves the pointer alone and sets
// a sticky error. Assumes push and pop are never requested together.
module fcu_stack #(
    parameter int DEPTH_BYTES = 256,
    parameter int BYTE_W      = 8,
    parameter int ENTRY_BYTES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [ENTRY_BYTES*BYTE_W-1:0] push_data,
    output logic [ENTRY_BYTES*BYTE_W-1:0] top_data,
    output logic                          can_push,
    output logic                          can_pop,
    output logic                          err
);

    localparam int SPW = $clog2(DEPTH_BYTES + 1);
    localparam int IW  = (DEPTH_BYTES > 1) ? $clog2(DEPTH_BYTES) : 1;
    localparam logic [SPW-1:0] PUSH_LIMIT = SPW'(DEPTH_BYTES - ENTRY_BYTES);
    localparam logic [SPW-1:0] STEP       = SPW'(ENTRY_BYTES);

    logic [BYTE_W-1:0] mem [DEPTH_BYTES];
    logic [SPW-1:0]    sp;

    // Room and content checks on the byte pointer
    always_comb begin
        can_push = (sp <= PUSH_LIMIT);
        can_pop  = (sp >= STEP);
    end

    // Read the top entry, low byte at the lower address
    for (genvar b = 0; b < ENTRY_BYTES; b++) begin : g_rd
        logic [SPW-1:0] rd_idx;
        assign rd_idx = sp - STEP + SPW'(b);
        assign top_data[b*BYTE_W +: BYTE_W] = mem[IW'(rd_idx)];
    end

    // Write all bytes of a pushed entry
    always_ff @(posedge clk) begin
        if (push && can_push) begin
            for (int b = 0; b < ENTRY_BYTES; b++) begin
                mem[IW'(sp + SPW'(b))] <= push_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Stack pointer and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp  <= '0;
            err <= 1'b0;
        end else if (push) begin
            if (can_push) sp  <= sp + STEP;
            else          err <= 1'b1;
        end else if (pop) begin
            if (can_pop)  sp  <= sp - STEP;
            else          err <= 1'b1;
        end
    end

endmodule

// File: rtl/flow_ctrl_unit.sv
// flow_ctrl_unit: program counter and next-address selection for a small
// 8-bit processor. One instruction is consumed per cycle with instr_valid
// high; pc updates on that edge. Return immediate and increment results are
// combinational so neighbours can write them on the same edge.
// Assumes the address operand bytes are already gathered by fetch.
module flow_ctrl_unit
    import fcu_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int STACK_BYTES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [BYTE_W-1:0]    addr_lo,
    input  logic [BYTE_W-1:0]    addr_hi,
    input  logic                 acc_zero,
    input  logic                 carry_flag,
    input  logic                 test_pin,
    input  logic [BYTE_W-1:0]    isz_reg_in,
    output logic [2*BYTE_W-1:0]  pc,
    output logic                 acc_load,
    output logic [3:0]           acc_imm,
    output logic [BYTE_W-1:0]    isz_result,
    output logic                 isz_zero,
    output logic                 stack_err
);

    localparam int PC_W     = 2 * BYTE_W;
    localparam int NCOND    = 3;
    localparam int ENTRY_B  = PC_W / BYTE_W;

    flow_dec_t          dec;
    logic               cond_taken;
    logic [PC_W-1:0]    target;
    logic [PC_W-1:0]    seq_pc;
    logic [PC_W-1:0]    call_ret;
    logic [PC_W-1:0]    top_addr;
    logic [PC_W-1:0]    next_pc;
    logic               do_push;
    logic               do_pop;
    logic               can_push;
    logic               can_pop;

    fcu_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    fcu_cond #(.NSRC(NCOND)) u_cond (
        .mask    (dec.cond),
        .sources ({test_pin, carry_flag, acc_zero}),
        .taken   (cond_taken)
    );

    fcu_stack #(
        .DEPTH_BYTES (STACK_BYTES),
        .BYTE_W      (BYTE_W),
        .ENTRY_BYTES (ENTRY_B)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (call_ret),
        .top_data  (top_addr),
        .can_push  (can_push),
        .can_pop   (can_pop),
        .err       (stack_err)
    );

    // Address arithmetic shared by all flow kinds
    always_comb begin
        target   = {addr_hi, addr_lo};
        seq_pc   = pc + PC_W'(dec.len);
        call_ret = pc + PC_W'(3);
    end

    // Increment result for increment-and-branch
    always_comb begin
        isz_result = isz_reg_in + BYTE_W'(1);
        isz_zero   = (isz_result == '0);
    end

    // Stack requests and accumulator load
    always_comb begin
        do_push  = instr_valid && (dec.kind == FK_CALL);
        do_pop   = instr_valid && (dec.kind == FK_RET);
        acc_load = do_pop;
        acc_imm  = dec.imm;
    end

    // Next program counter selection
    always_comb begin
        unique case (dec.kind)
            FK_JUMP: next_pc = target;
            FK_COND: next_pc = cond_taken ? target : seq_pc;
            FK_CALL: next_pc = can_push ? target : seq_pc;
            FK_RET:  next_pc = can_pop ? top_addr : seq_pc;
            FK_ISZ:  next_pc = isz_zero ? seq_pc : target;
            default: next_pc = seq_pc;
        endcase
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)           pc <= '0;
        else if (instr_valid) pc <= next_pc;
    end

endmodule

// File: rtl/fcu_checker.sv
// fcu_checker: temporal properties of flow_ctrl_unit, bound to every
// instance. Observes ports only.
module fcu_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                instr_valid,
    input logic [7:0]          opcode,
    input logic [BYTE_W-1:0]   addr_lo,
    input logic [BYTE_W-1:0]   addr_hi,
    input logic [2*BYTE_W-1:0] pc,
    input logic                acc_load,
    input logic                isz_zero,
    input logic                stack_err
);

    AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err); // R10

    AST_ACC_ONLY_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load |-> (instr_valid && opcode[7:4] == 4'hC)); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode == 8'h40) |=> pc == $past({addr_hi, addr_lo})); // R3

    AST_ISZ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode[7:4] == 4'h7 && !opcode[0] && isz_zero)
        |=> pc == $past(pc) + 16'd3); // R7

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stack_err) |-> ($past(instr_valid)
            && ($past(opcode) == 8'h50 || $past(opcode[7:4]) == 4'hC))); // R8

endmodule

bind flow_ctrl_unit fcu_checker #(.BYTE_W(BYTE_W)) u_fcu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .addr_lo     (addr_lo),
    .addr_hi     (addr_hi),
    .pc          (pc),
    .acc_load    (acc_load),
    .isz_zero    (isz_zero),
    .stack_err   (stack_err)
);

// File: tb/flow_ctrl_unit_bench.sv
// Bench for flow_ctrl_unit: a vector table walked from reset, then directed
// tests for reset, stack overflow/unwind, idle cycles and PC wrap.
module flow_ctrl_unit_bench;

    localparam int STK = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  addr_lo = '0;
    logic [7:0]  addr_hi = '0;
    logic        acc_zero = 1'b0;
    logic        carry_flag = 1'b0;
    logic        test_pin = 1'b0;
    logic [7:0]  isz_reg_in = '0;
    logic [15:0] pc;
    logic        acc_load;
    logic [3:0]  acc_imm;
    logic [7:0]  isz_result;
    logic        isz_zero;
    logic        stack_err;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flow_ctrl_unit #(.BYTE_W(8), .STACK_BYTES(STK)) u_flow_ctrl_unit (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid),
        .opcode (opcode), .addr_lo (addr_lo), .addr_hi (addr_hi),
        .acc_zero (acc_zero), .carry_flag (carry_flag), .test_pin (test_pin),
        .isz_reg_in (isz_reg_in), .pc (pc), .acc_load (acc_load),
        .acc_imm (acc_imm), .isz_result (isz_result), .isz_zero (isz_zero),
        .stack_err (stack_err)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] tgt;
        logic        az;
        logic        cy;
        logic        tp;
        logic [7:0]  regv;
        logic [15:0] exp_pc;
        logic        exp_acc;
        logic [3:0]  exp_imm;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0001, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 one byte
        '{8'h20, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0003, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 two bytes
        '{8'h21, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0004, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 one byte
        '{8'h33, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0007, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 three bytes
        '{8'h30, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0008, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 one byte
        '{8'h7F, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h000B, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 three bytes
        '{8'hE1, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h000D, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 port write
        '{8'hEA, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h000F, 1'b0, 4'h0, 1'b0, 4'd2},  // R2 port read
        '{8'h40, 16'h1234, 1'b0, 1'b0, 1'b0, 8'h00, 16'h1234, 1'b0, 4'h0, 1'b0, 4'd3},  // R3
        '{8'h14, 16'h2000, 1'b1, 1'b0, 1'b0, 8'h00, 16'h2000, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 zero taken
        '{8'h14, 16'h2F00, 1'b0, 1'b0, 1'b0, 8'h00, 16'h2003, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 zero not
        '{8'h1C, 16'h3000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h3000, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 inverted
        '{8'h1C, 16'h3F00, 1'b1, 1'b0, 1'b0, 8'h00, 16'h3003, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 inverted not
        '{8'h12, 16'h4000, 1'b0, 1'b1, 1'b0, 8'h00, 16'h4000, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 carry
        '{8'h11, 16'h5000, 1'b0, 1'b0, 1'b1, 8'h00, 16'h5000, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 test
        '{8'h11, 16'h5F00, 1'b1, 1'b1, 1'b0, 8'h00, 16'h5003, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 test low
        '{8'h13, 16'h6000, 1'b0, 1'b0, 1'b1, 8'h00, 16'h6000, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 OR
        '{8'h10, 16'h6F00, 1'b1, 1'b1, 1'b1, 8'h00, 16'h6003, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 empty mask
        '{8'h18, 16'h7000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h7000, 1'b0, 4'h0, 1'b0, 4'd4},  // R4 invert only
        '{8'h50, 16'h8000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h8000, 1'b0, 4'h0, 1'b0, 4'd5},  // R5 push 7003
        '{8'h50, 16'h9000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h9000, 1'b0, 4'h0, 1'b0, 4'd5},  // R5 push 8003
        '{8'h72, 16'hA000, 1'b0, 1'b0, 1'b0, 8'h05, 16'hA000, 1'b0, 4'h0, 1'b0, 4'd7},  // R7 branch
        '{8'h74, 16'hB000, 1'b0, 1'b0, 1'b0, 8'hFF, 16'hA003, 1'b0, 4'h0, 1'b0, 4'd7},  // R7 wraps to 0
        '{8'hC7, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h8003, 1'b1, 4'h7, 1'b0, 4'd6},  // R6
        '{8'hC0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h7003, 1'b1, 4'h0, 1'b0, 4'd6},  // R6
        '{8'hC5, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h7004, 1'b1, 4'h5, 1'b1, 4'd9},  // R9 underflow
        '{8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h7005, 1'b0, 4'h0, 1'b1, 4'd10}  // R10 sticky
    };

    // Record one check
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Present one instruction for one cycle
    task automatic drive(input logic [7:0] op, input logic [15:0] tgt,
                         input logic az, input logic cy, input logic tp,
                         input logic [7:0] regv);
        @(negedge clk);
        instr_valid = 1'b1;
        opcode      = op;
        addr_lo     = tgt[7:0];
        addr_hi     = tgt[15:8];
        acc_zero    = az;
        carry_flag  = cy;
        test_pin    = tp;
        isz_reg_in  = regv;
        #1;
    endtask

    // Wait past the edge that consumes the instruction
    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    // Issue a simple instruction and check pc afterwards
    task automatic step_pc(input logic [7:0] op, input logic [15:0] tgt,
                           input logic [15:0] exp_pc, input string req);
        drive(op, tgt, 1'b0, 1'b0, 1'b0, 8'h00);
        settle();
        chk(pc === exp_pc, req, "pc", pc, exp_pc);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        string rq;
        logic [7:0] exp_r;
        repeat (3) @(posedge clk);
        #1;
        chk(pc === 16'h0000, "R1", "pc after reset", pc, 0);
        chk(stack_err === 1'b0, "R1", "err after reset", stack_err, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d vec%0d", VECS[i].req, i);
            drive(VECS[i].op, VECS[i].tgt, VECS[i].az, VECS[i].cy,
                  VECS[i].tp, VECS[i].regv);
            exp_r = VECS[i].regv + 8'd1;
            chk(acc_load === VECS[i].exp_acc, rq, "acc_load", acc_load, VECS[i].exp_acc);
            if (VECS[i].exp_acc)
                chk(acc_imm === VECS[i].exp_imm, rq, "acc_imm", acc_imm, VECS[i].exp_imm);
            chk(isz_result === exp_r, rq, "isz_result", isz_result, exp_r);
            chk(isz_zero === (exp_r == 8'h00), rq, "isz_zero", isz_zero, exp_r == 8'h00);
            settle();
            chk(pc === VECS[i].exp_pc, rq, "pc", pc, VECS[i].exp_pc);
            chk(stack_err === VECS[i].exp_err, rq, "stack_err", stack_err, VECS[i].exp_err);
        end

        // R1: reset mid-run clears pc and the sticky error
        @(negedge clk);
        instr_valid = 1'b0;
        rst_n = 1'b0;
        settle();
        chk(pc === 16'h0000, "R1", "pc after second reset", pc, 0);
        chk(stack_err === 1'b0, "R1", "err after second reset", stack_err, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: fill four levels, then overflow
        step_pc(8'h50, 16'h0100, 16'h0100, "R5");
        step_pc(8'h50, 16'h0200, 16'h0200, "R5");
        step_pc(8'h50, 16'h0300, 16'h0300, "R5");
        step_pc(8'h50, 16'h0400, 16'h0400, "R5");
        chk(stack_err === 1'b0, "R8", "err at exactly full", stack_err, 0);
        step_pc(8'h50, 16'h0500, 16'h0403, "R8");
        chk(stack_err === 1'b1, "R8", "err on overflow", stack_err, 1);

        // R6/R8: unwind in last-in first-out order, entries untouched
        step_pc(8'hC1, 16'h0000, 16'h0303, "R8");
        step_pc(8'hC2, 16'h0000, 16'h0203, "R6");
        step_pc(8'hC3, 16'h0000, 16'h0103, "R6");
        step_pc(8'hC4, 16'h0000, 16'h0003, "R6");

        // R11: idle cycles with flow opcodes on the bus
        drive(8'hC9, 16'hBEEF, 1'b1, 1'b1, 1'b1, 8'h00);
        instr_valid = 1'b0;
        #1;
        chk(acc_load === 1'b0, "R11", "acc_load while idle", acc_load, 0);
        settle();
        chk(pc === 16'h0003, "R11", "pc idle return", pc, 16'h0003);
        @(negedge clk);
        opcode = 8'h40;
        settle();
        chk(pc === 16'h0003, "R11", "pc idle jump", pc, 16'h0003);

        // R2: wrap at the top of the address space
        step_pc(8'h40, 16'hFFFE, 16'hFFFE, "R3");
        step_pc(8'h20, 16'h0000, 16'h0000, "R2");

        // R10: error survives further clean traffic
        step_pc(8'h00, 16'h0000, 16'h0001, "R2");
        chk(stack_err === 1'b1, "R10", "err still set", stack_err, 1);

        @(negedge clk);
        instr_valid = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule